// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave (256 x 8) with Write-Protect Cancel

This block models a 256-byte non-volatile memory that answers as a slave on a two-wire serial bus. A fast system clock oversamples the serial clock and data lines. From them the block detects bus start and stop conditions, recognises its own 7-bit device address, and takes one 8-bit word address byte. A master can write from one to many bytes within an 8-byte page. It can read with random addressing, from the current-address pointer, or sequentially across the whole array. After a write transaction ends with a stop condition, an internal programming cycle of a set number of system clocks runs before the bytes appear in the array. While that cycle runs the device does not answer its address, so a master finds out that the write has finished by polling.

A write-protect input guards the array. If it is high at any point from the serial clock rise that captures the last bit of the first data byte until the stop condition, no programming cycle starts. If it goes high while the programming cycle runs, the cycle is aborted at once and the array keeps its old contents. The data line is open-drain: the block only ever pulls it low through `sda_oe`.

Top module: `twe_eeprom`

## Requirements
- R1: The device address byte is `1010` followed by `strap_i[2]`, `strap_i[1]`, `strap_i[0]` in bits 7..1, and bit 0 is 1 for a read. A byte with any other value in bits 7..1 gets no acknowledge, and the block pulls SDA low nowhere until the next START.
- R2: In a write, the block acknowledges the device, word-address and data bytes by pulling SDA low through the ninth clock. After a STOP, the data bytes are found in the array once the programming cycle has ended.
- R3: During a write, the word address advances only in its low 3 bits, so a write that runs past the end of an 8-byte page wraps to the start of the same page, and a later byte overwrites an earlier one.
- R4: A random read (device write, word address, repeated START, device read) returns the byte stored at that word address.
- R5: A sequential read returns successive addresses and wraps from 255 to 0.
- R6: A current-address read returns the byte one past the last byte read, or one past the last byte written with the page wrap of R3 applied.
- R7: For WR_CYCLES system clocks after a STOP that starts a write, the device address is not acknowledged; afterwards it is.
- R8: WP high at any point from the SCL rise that captures bit 0 of the first data byte up to the STOP cancels the write: no busy period follows and the array is unchanged. WP high only before that rise has no effect.
- R9: WP going high during the programming cycle ends it at once: the device acknowledges again immediately and the array is unchanged.
- R10: The block changes its drive on SDA only while SCL is low.
- R11: After reset, SDA is released and the device is idle and not busy.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe | output | 1 | 1 pulls the data line low, 0 releases it |
| strap_i | input | 3 | Low three bits of the device address |
| wp_i | input | 1 | Write-protect, active high |

## Verification
The two functions that can meet in one cycle are the start of the programming cycle on a STOP and the write-protect check. WP is raised inside the data phase and dropped again before the STOP, raised only during the word address, or pulsed a few clocks into the programming cycle. Each case is judged by whether the device acknowledges an address poll right after the STOP or the pulse, and by reading the page back against a bench model of the array. Random page writes, random, current and sequential reads, together with address polling, run in between these directed cases.

// File: rtl/twe_pkg.sv
package twe_pkg;
  localparam int unsigned ADDR_W = 8;
  localparam int unsigned BYTE_W = 8;
  localparam logic [3:0] DEV_PREFIX = 4'b1010;

  typedef enum logic [2:0] {
    ST_IDLE, ST_DEV, ST_WORD, ST_WDAT, ST_RDAT, ST_ACKO, ST_ACKI, ST_SKIP
  } twe_state_e;
endpackage

// File: rtl/twe_bus_sync.sv
module twe_bus_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic bus_start,
  output logic bus_stop
);
  localparam int unsigned STAGES = 3;

  logic [STAGES-1:0] scl_pipe, sda_pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
    end
  end

  logic scl_prev, sda_prev;
  assign scl_lvl   = scl_pipe[STAGES-2];
  assign sda_lvl   = sda_pipe[STAGES-2];
  assign scl_prev  = scl_pipe[STAGES-1];
  assign sda_prev  = sda_pipe[STAGES-1];
  assign scl_rise  = scl_lvl & ~scl_prev;
  assign scl_fall  = ~scl_lvl & scl_prev;
  assign bus_start = scl_lvl & scl_prev & sda_prev & ~sda_lvl;
  assign bus_stop  = scl_lvl & scl_prev & ~sda_prev & sda_lvl;
endmodule

// File: rtl/twe_store.sv
module twe_store #(
  parameter int unsigned PAGE_W    = 3,
  parameter int unsigned WR_CYCLES = 2000
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic [twe_pkg::ADDR_W-1:0]             rd_addr,
  output logic [twe_pkg::BYTE_W-1:0]             rd_data,
  input  logic                                   buf_clr,
  input  logic [twe_pkg::ADDR_W-PAGE_W-1:0]      buf_base,
  input  logic                                   buf_we,
  input  logic [PAGE_W-1:0]                      buf_idx,
  input  logic [twe_pkg::BYTE_W-1:0]             buf_data,
  input  logic                                   go,
  input  logic                                   wp_i,
  output logic                                   busy
);
  localparam int unsigned DEPTH = 1 << twe_pkg::ADDR_W;
  localparam int unsigned PAGE  = 1 << PAGE_W;
  localparam int unsigned CW    = $clog2(WR_CYCLES + 1);

  logic [twe_pkg::BYTE_W-1:0]        mem  [DEPTH];
  logic [twe_pkg::BYTE_W-1:0]        pbuf [PAGE];
  logic [PAGE-1:0]                   mask;
  logic [twe_pkg::ADDR_W-PAGE_W-1:0] base_q;
  logic [CW-1:0]                     tmr, tmr_n;
  logic                              busy_n, commit;

  assign rd_data = mem[rd_addr];

  // programming-cycle timer: next state
  always_comb begin
    busy_n = busy;
    tmr_n  = tmr;
    commit = 1'b0;
    if (busy) begin
      if (wp_i) begin
        busy_n = 1'b0;
      end else if (tmr == CW'(WR_CYCLES - 1)) begin
        busy_n = 1'b0;
        commit = 1'b1;
      end else begin
        tmr_n = tmr + 1'b1;
      end
    end else if (go && !wp_i) begin
      busy_n = 1'b1;
      tmr_n  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      tmr    <= '0;
      mask   <= '0;
      base_q <= '0;
    end else begin
      busy <= busy_n;
      tmr  <= tmr_n;
      if (buf_clr) begin
        mask   <= '0;
        base_q <= buf_base;
      end else if (buf_we) begin
        mask[buf_idx] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (buf_we) pbuf[buf_idx] <= buf_data;
  end

  always_ff @(posedge clk) begin
    if (commit) begin
      for (int i = 0; i < PAGE; i++) begin
        if (mask[i]) mem[{base_q, i[PAGE_W-1:0]}] <= pbuf[i];
      end
    end
  end

  // R9: a protect pulse during programming ends the busy period next cycle
  p_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wp_i) |=> !busy);
  // R7: the busy timer never passes the programmed length
  p_tmr_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (tmr < CW'(WR_CYCLES)));
  // R2: an accepted write request starts the programming cycle
  p_go_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (go && !wp_i && !busy) |=> busy);
endmodule

// File: rtl/twe_ctrl.sv
module twe_ctrl #(
  parameter int unsigned PAGE_W = 3
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               scl_lvl,
  input  logic                               sda_lvl,
  input  logic                               scl_rise,
  input  logic                               scl_fall,
  input  logic                               bus_start,
  input  logic                               bus_stop,
  input  logic [2:0]                         strap_i,
  input  logic                               wp_i,
  input  logic                               busy,
  input  logic [twe_pkg::BYTE_W-1:0]         rd_data,
  output logic                               sda_oe,
  output logic [twe_pkg::ADDR_W-1:0]         rd_addr,
  output logic                               buf_clr,
  output logic [twe_pkg::ADDR_W-PAGE_W-1:0]  buf_base,
  output logic                               buf_we,
  output logic [PAGE_W-1:0]                  buf_idx,
  output logic [twe_pkg::BYTE_W-1:0]         buf_data,
  output logic                               go
);
  import twe_pkg::*;

  localparam logic [3:0] LAST_BIT = 4'd8;

  twe_state_e             state, state_n, ret, ret_n;
  logic [3:0]             cnt, cnt_n;
  logic [BYTE_W-1:0]      sh, sh_n;
  logic [ADDR_W-1:0]      addr, addr_n;
  logic                   oe_n, seen, seen_n, cancel, cancel_n, mack, mack_n;
  logic [PAGE_W-1:0]      low_inc;
  logic                   byte_end, dev_hit;

  assign low_inc  = addr[PAGE_W-1:0] + {{(PAGE_W-1){1'b0}}, 1'b1};
  assign byte_end = scl_fall && (cnt == LAST_BIT);
  assign dev_hit  = (sh[7:1] == {DEV_PREFIX, strap_i}) && !busy;

  assign rd_addr  = addr;
  assign buf_clr  = (state == ST_WORD) && byte_end;
  assign buf_base = sh[ADDR_W-1:PAGE_W];
  assign buf_we   = (state == ST_WDAT) && byte_end;
  assign buf_idx  = addr[PAGE_W-1:0];
  assign buf_data = sh;
  assign go       = bus_stop && seen && !cancel;

  always_comb begin
    state_n  = state;
    ret_n    = ret;
    cnt_n    = cnt;
    sh_n     = sh;
    addr_n   = addr;
    oe_n     = sda_oe;
    seen_n   = seen;
    cancel_n = cancel | (wp_i & seen);
    mack_n   = mack;
    if (bus_start) begin
      state_n  = ST_DEV;
      cnt_n    = '0;
      oe_n     = 1'b0;
      seen_n   = 1'b0;
      cancel_n = 1'b0;
    end else if (bus_stop) begin
      state_n  = ST_IDLE;
      oe_n     = 1'b0;
      seen_n   = 1'b0;
      cancel_n = 1'b0;
    end else begin
      unique case (state)
        ST_DEV, ST_WORD, ST_WDAT: begin
          if (scl_rise && cnt < LAST_BIT) begin
            sh_n  = {sh[BYTE_W-2:0], sda_lvl};
            cnt_n = cnt + 1'b1;
            if (state == ST_WDAT && cnt == LAST_BIT - 1'b1) begin
              seen_n   = 1'b1;              // D0 of a data byte: window opens
              cancel_n = cancel | wp_i;
            end
          end else if (byte_end) begin
            cnt_n = '0;
            if (state == ST_DEV) begin
              if (dev_hit) begin
                oe_n    = 1'b1;
                state_n = ST_ACKO;
                ret_n   = sh[0] ? ST_RDAT : ST_WORD;
              end else begin
                state_n = ST_SKIP;
              end
            end else begin
              addr_n  = (state == ST_WORD) ? sh : {addr[ADDR_W-1:PAGE_W], low_inc};
              oe_n    = 1'b1;
              state_n = ST_ACKO;
              ret_n   = ST_WDAT;
            end
          end
        end
        ST_ACKO: begin
          if (scl_fall) begin
            state_n = ret;
            if (ret == ST_RDAT) begin
              sh_n   = rd_data;
              oe_n   = ~rd_data[BYTE_W-1];
              addr_n = addr + 1'b1;
            end else begin
              oe_n = 1'b0;
            end
          end
        end
        ST_RDAT: begin
          if (scl_rise) begin
            cnt_n = cnt + 1'b1;
          end else if (scl_fall) begin
            if (cnt == LAST_BIT) begin
              oe_n    = 1'b0;
              cnt_n   = '0;
              state_n = ST_ACKI;
            end else begin
              sh_n = {sh[BYTE_W-2:0], 1'b0};
              oe_n = ~sh[BYTE_W-2];
            end
          end
        end
        ST_ACKI: begin
          if (scl_rise) begin
            mack_n = ~sda_lvl;
          end else if (scl_fall) begin
            if (mack) begin
              sh_n    = rd_data;
              oe_n    = ~rd_data[BYTE_W-1];
              addr_n  = addr + 1'b1;
              state_n = ST_RDAT;
            end else begin
              state_n = ST_SKIP;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      ret    <= ST_IDLE;
      cnt    <= '0;
      sh     <= '0;
      addr   <= '0;
      sda_oe <= 1'b0;
      seen   <= 1'b0;
      cancel <= 1'b0;
      mack   <= 1'b0;
    end else begin
      state  <= state_n;
      ret    <= ret_n;
      cnt    <= cnt_n;
      sh     <= sh_n;
      addr   <= addr_n;
      sda_oe <= oe_n;
      seen   <= seen_n;
      cancel <= cancel_n;
      mack   <= mack_n;
    end
  end

  // R10: the drive on SDA only moves while the sampled clock is low
  p_edge_scl_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sda_oe) && !$past(bus_start) && !$past(bus_stop)) |-> !$past(scl_lvl));
  // R2: the acknowledge is held for the whole ninth clock
  p_ack_drive_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ACKO) |-> sda_oe);
  // R7: a device byte that ends while programming runs is not acknowledged
  p_busy_nack_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DEV && byte_end && busy) |=> !sda_oe);
  // R1: nothing is driven while ignoring a foreign transaction
  p_skip_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SKIP) |-> !sda_oe);
endmodule

// File: rtl/twe_eeprom.sv
module twe_eeprom #(
  parameter int unsigned PAGE_W    = 3,
  parameter int unsigned WR_CYCLES = 2000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic [2:0] strap_i,
  input  logic       wp_i
);
  import twe_pkg::*;

  logic scl_lvl, sda_lvl, scl_rise, scl_fall, bus_start, bus_stop;
  logic busy, buf_clr, buf_we, go;
  logic [ADDR_W-1:0]        rd_addr;
  logic [BYTE_W-1:0]        rd_data, buf_data;
  logic [ADDR_W-PAGE_W-1:0] buf_base;
  logic [PAGE_W-1:0]        buf_idx;

  twe_bus_sync u_sync (
    .clk, .rst_n, .scl_i, .sda_i,
    .scl_lvl, .sda_lvl, .scl_rise, .scl_fall, .bus_start, .bus_stop
  );

  twe_ctrl #(.PAGE_W(PAGE_W)) u_ctrl (
    .clk, .rst_n, .scl_lvl, .sda_lvl, .scl_rise, .scl_fall,
    .bus_start, .bus_stop, .strap_i, .wp_i, .busy, .rd_data,
    .sda_oe, .rd_addr, .buf_clr, .buf_base, .buf_we, .buf_idx, .buf_data, .go
  );

  twe_store #(.PAGE_W(PAGE_W), .WR_CYCLES(WR_CYCLES)) u_store (
    .clk, .rst_n, .rd_addr, .rd_data, .buf_clr, .buf_base,
    .buf_we, .buf_idx, .buf_data, .go, .wp_i, .busy
  );
endmodule

// File: tb/twe_eeprom_tb.sv
module twe_eeprom_tb;
  localparam int WRC = 300;
  localparam int H   = 8;
  localparam logic [2:0] STRAP = 3'b101;
  localparam logic [6:0] DEV   = {4'b1010, STRAP};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic m_low = 1'b0;
  logic wp = 1'b0;
  logic sda_oe;
  wire  sda = ~(m_low | sda_oe);

  always #5 clk = ~clk;

  twe_eeprom #(.PAGE_W(3), .WR_CYCLES(WRC)) u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda),
    .sda_oe(sda_oe), .strap_i(STRAP), .wp_i(wp)
  );

  int n_chk = 0, n_bad = 0, viol = 0;
  logic [7:0] mdl [256];
  bit         mval [256];
  logic [7:0] ptr = 8'h00;
  logic [7:0] wbuf [16];
  logic [7:0] rbuf [16];

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // R10 monitor: drive must not move after SCL has been high a while
  logic prev_oe = 1'b0;
  int   hi_cnt = 0;
  always @(negedge clk) begin
    if (rst_n && scl && hi_cnt >= 4 && sda_oe != prev_oe) viol++;
    hi_cnt  = scl ? hi_cnt + 1 : 0;
    prev_oe = sda_oe;
  end

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic b_start();
    wt(2); m_low = 1'b0; wt(H); scl = 1'b1; wt(H); m_low = 1'b1; wt(H); scl = 1'b0;
  endtask

  task automatic b_stop();
    wt(2); m_low = 1'b1; wt(H); scl = 1'b1; wt(H); m_low = 1'b0; wt(H);
  endtask

  task automatic send_bit(input logic b);
    wt(2); m_low = ~b; wt(H - 2); scl = 1'b1; wt(H); scl = 1'b0;
  endtask

  task automatic tx_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    wt(2); m_low = 1'b0; wt(H - 2); scl = 1'b1; wt(H / 2);
    ack = (sda == 1'b0);
    wt(H / 2); scl = 1'b0;
  endtask

  task automatic rx_byte(input logic give_ack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      wt(2); m_low = 1'b0; wt(H - 2); scl = 1'b1; wt(H / 2);
      b[i] = sda;
      wt(H / 2); scl = 1'b0;
    end
    send_bit(~give_ack);
  endtask

  // one address poll; returns 1 if acknowledged
  task automatic poll(output logic ack);
    b_start(); tx_byte({DEV, 1'b0}, ack); b_stop();
  endtask

  task automatic wait_ready(input string tag);
    logic a;
    int   k = 0;
    do begin poll(a); k++; end while (!a && k < 40);
    chk(tag, a, 1);
  endtask

  // wpm: 0 none, 1 WP high only during the word address, 2 WP high in the data phase
  task automatic do_write(input logic [7:0] a, input int n, input int wpm, input bit commit);
    logic ack, all_ok;
    all_ok = 1'b1;
    b_start();
    tx_byte({DEV, 1'b0}, ack); all_ok &= ack;
    if (wpm == 1) wp = 1'b1;
    tx_byte(a, ack); all_ok &= ack;
    if (wpm == 1) wp = 1'b0;
    for (int i = 0; i < n; i++) begin
      tx_byte(wbuf[i], ack); all_ok &= ack;
      if (wpm == 2 && i == 0) wp = 1'b1;
    end
    if (wpm == 2) begin wt(3); wp = 1'b0; end
    b_stop();
    chk("R2 write bytes acknowledged", all_ok, 1);
    for (int i = 0; i < n; i++) begin
      logic [7:0] ad;
      ad = {a[7:3], 3'(a[2:0] + 3'(i))};
      if (commit) begin mdl[ad] = wbuf[i]; mval[ad] = 1'b1; end
    end
    ptr = {a[7:3], 3'(a[2:0] + 3'(n))};
  endtask

  task automatic rd_seq(input int n, input string tag);
    logic [7:0] b;
    for (int i = 0; i < n; i++) begin
      rx_byte(i != n - 1, b);
      if (mval[ptr]) chk(tag, b, mdl[ptr]);
      ptr = ptr + 8'd1;
    end
    b_stop();
  endtask

  task automatic rd_rand(input logic [7:0] a, input int n, input string tag);
    logic ack;
    b_start(); tx_byte({DEV, 1'b0}, ack); tx_byte(a, ack);
    b_start(); tx_byte({DEV, 1'b1}, ack);
    chk("R4 read address acknowledged", ack, 1);
    ptr = a;
    rd_seq(n, tag);
  endtask

  task automatic rd_cur(input int n, input string tag);
    logic ack;
    b_start(); tx_byte({DEV, 1'b1}, ack);
    chk("R6 current read acknowledged", ack, 1);
    rd_seq(n, tag);
  endtask

  task automatic finish_run();
    chk("R10 SDA drive changed while SCL high", viol, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog R1..all act=running exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic a;
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < 256; i++) mval[i] = 1'b0;
    wt(4); rst_n = 1'b1; wt(4);
    chk("R11 SDA released after reset", sda_oe, 0);
    poll(a);
    chk("R11 idle and not busy after reset", a, 1);

    // R1: foreign address is ignored, also for the byte after it
    b_start(); tx_byte({4'b1010, 3'b001, 1'b0}, a);
    chk("R1 foreign address not acknowledged", a, 0);
    tx_byte(8'h00, a);
    chk("R1 following byte ignored", a, 0);
    b_stop();

    // R2 / R7: short write then busy polling
    wbuf[0] = 8'hA5; wbuf[1] = 8'h3C; wbuf[2] = 8'h96;
    do_write(8'h10, 3, 0, 1);
    poll(a);
    chk("R7 address refused right after STOP", a, 0);
    wait_ready("R7 address accepted after programming");
    rd_rand(8'h10, 3, "R4 random read after write");

    // R3: 10 bytes from 0x25 wrap inside page 0x20
    for (int i = 0; i < 10; i++) wbuf[i] = 8'(8'h40 + i);
    do_write(8'h25, 10, 0, 1);
    wait_ready("R7 ready after page write");
    rd_rand(8'h20, 8, "R3 page wrap contents");

    // R6: current address after a write lands past last byte with wrap
    for (int i = 0; i < 2; i++) wbuf[i] = 8'(8'hC0 + i);
    do_write(8'h1E, 2, 0, 1);
    wait_ready("R7 ready");
    ptr = 8'h18;
    rd_cur(1, "R6 current address after page-wrapped write");

    // R5: sequential read across 255 -> 0
    for (int i = 0; i < 8; i++) wbuf[i] = 8'(8'h70 + 3 * i);
    do_write(8'hF8, 8, 0, 1);
    wait_ready("R7 ready");
    for (int i = 0; i < 8; i++) wbuf[i] = 8'(8'h90 + i);
    do_write(8'h00, 8, 0, 1);
    wait_ready("R7 ready");
    rd_rand(8'hFD, 6, "R5 sequential wrap 255 to 0");
    rd_cur(2, "R6 current address after read");

    // R8: protect inside the window cancels
    for (int i = 0; i < 3; i++) wbuf[i] = 8'(8'hE0 + i);
    do_write(8'h10, 3, 2, 0);
    poll(a);
    chk("R8 no busy period after cancelled write", a, 1);
    rd_rand(8'h10, 3, "R8 array unchanged after cancel");

    // R8: protect only before the window has no effect
    for (int i = 0; i < 2; i++) wbuf[i] = 8'(8'h5A + i);
    do_write(8'h48, 2, 1, 1);
    poll(a);
    chk("R8 early protect still starts programming", a, 0);
    wait_ready("R7 ready");
    rd_rand(8'h48, 2, "R8 early protect write stored");

    // R9: protect during programming aborts
    for (int i = 0; i < 4; i++) wbuf[i] = 8'(8'h11 * (i + 1));
    do_write(8'h20, 4, 0, 0);
    wt(20); wp = 1'b1; wt(4); wp = 1'b0;
    poll(a);
    chk("R9 acknowledged right after abort", a, 1);
    rd_rand(8'h20, 4, "R9 array unchanged after abort");

    // random mix
    for (int it = 0; it < 28; it++) begin
      int op, n;
      logic [7:0] ad;
      op = $urandom_range(2, 0);
      ad = 8'($urandom());
      if (op == 0) begin
        n = $urandom_range(9, 1);
        for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom());
        do_write(ad, n, 0, 1);
        wait_ready("R7 ready after random write");
      end else if (op == 1) begin
        rd_rand(ad, $urandom_range(6, 1), "R4 random read");
      end else begin
        rd_cur($urandom_range(4, 1), "R5 current sequential read");
      end
    end
    finish_run();
  end
endmodule